// File: doc/BRIEF.md
# Periodic Down-Counting Tick Timer

This block is a free-running periodic timer for a processor subsystem. A counter of `CNT_W` bits (24 by default) counts down by one on every active tick. When it has reached zero, the next active tick reloads it from a programmable reload register, so the period is the reload value plus one tick. Each time the count steps from one to zero, the block sets a sticky wrap flag and, if interrupts are enabled, pulses an interrupt request for one cycle.

Software reaches the timer through a small word-aligned register bus with four registers:

- **Control/status** at offset 0x0.
- **Reload** at offset 0x4.
- **Current count** at offset 0x8.
- **Fixed calibration word** at offset 0xC.

Reading the control/status register returns the wrap flag and clears it. Writing any value to the current-count register zeroes the count and the flag, which forces a clean reload on the next tick without an interrupt. A reload value of zero parks the counter at zero. This stops the timer without touching the enable bit.

Ticks come either from the core clock or from an external reference signal, whose rising edges are synchronised into the clock domain. A debug-halt input freezes the counter while it is asserted.

Top module: `periodic_down_timer`

## Requirements
- R1: After reset, control/status, reload and current count all read 0, the calibration word reads 0x00000004, and `irq` is low.
- R2: An active tick is a clock cycle in which the following all hold: enable (control bit 0) is 1, a tick is present, and `dbg_halt` is low. On an active tick the count falls by exactly one if it is nonzero. Without an active tick the count holds.
- R3: An active tick that finds the count at zero loads the reload value into the count.
- R4: An active tick that steps the count from 1 to 0 sets the wrap flag (control bit 16). The flag stays set until it is cleared.
- R5: A read of control/status at offset 0x0 returns the flag as it is before the read, then clears it at the next edge. A flag set in that same cycle survives the read.
- R6: Writing any data to the current count at offset 0x8 sets the count and the flag to 0 at the next edge. The next active tick then loads the reload value. That write never produces an `irq` pulse, even in a cycle where the count would have stepped from 1 to 0.
- R7: With a reload value of 0 the count stays at 0, the flag never sets, and `irq` stays low.
- R8: While `dbg_halt` is 1 the count does not change. Bus accesses are still served.
- R9: `irq` is high for exactly the one cycle after a 1-to-0 step. It pulses only if interrupt enable (control bit 1) was 1 at that step.
- R10: With control bit 2 set to 1, every clock cycle is a tick. With bit 2 set to 0, each rising edge of `ref_tick` gives one tick after a `SYNC_STAGES`-deep synchroniser, and the count holds while `ref_tick` is idle.
- R11: Control/status exposes bits 0, 1 and 2 as writable, bit 16 as the flag, and all other bits as zero. Writes cannot set the flag. Reload and count read their upper 8 bits as zero. Writes to the calibration word have no effect. Address bits 1:0 are ignored.
- R12: A read returns register contents combinationally in the access cycle, so a count read shows the count before that cycle's edge. `bus_rdata` is zero when `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_wdata | input | DATA_W | Write data |
| bus_rd | input | 1 | Read strobe for one cycle |
| bus_rdata | output | DATA_W | Read data, valid in the cycle of `bus_rd` |
| dbg_halt | input | 1 | Debug halt; freezes the count |
| ref_tick | input | 1 | External reference tick, asynchronous |
| irq | output | 1 | One-cycle interrupt request on wrap |

## Verification
The bench aims a count write exactly at the cycle where the count is 1. A design that let that write through to the step logic would pulse `irq` or leave the flag set. It also aims a control/status read at the cycle of a 1-to-0 step; a design that gave the read-clear priority would drop that wrap event. Further directed cases cover a zero reload value, a halt in the middle of a countdown, writes to the flag bit and the calibration word, and ticks from the external reference. These catch, in turn: a counter that spins through the reload value, a halt that still reloads, a flag that software can set, and double or missed edge counting. Seeded random traffic with short reload values then drives many wraps, reads that clear the flag, and interrupt-enable changes against a cycle model computed in the bench.

// File: rtl/pdt_pkg.sv
package pdt_pkg;

   // Word index of each register (byte offset / 4)
   typedef enum logic [1:0] {
      REG_CTRL   = 2'd0,
      REG_RELOAD = 2'd1,
      REG_COUNT  = 2'd2,
      REG_CALIB  = 2'd3
   } pdt_reg_e;

   localparam int CTRL_EN_BIT   = 0;
   localparam int CTRL_IE_BIT   = 1;
   localparam int CTRL_SRC_BIT  = 2;
   localparam int CTRL_FLAG_BIT = 16;

   typedef struct packed {
      logic core_src;
      logic irq_en;
      logic run;
   } pdt_ctrl_t;

endpackage

// File: rtl/pdt_tick_gen.sv
module pdt_tick_gen #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic use_core,
   input  logic ref_in,
   output logic tick
);

   logic ref_level;
   logic ref_prev;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign ref_level = ref_in;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] sync_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               sync_q <= '0;
            end else begin
               sync_q[0] <= ref_in;
               for (int i = 1; i < SYNC_STAGES; i++) begin
                  sync_q[i] <= sync_q[i-1];
               end
            end
         end
         assign ref_level = sync_q[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) ref_prev <= 1'b0;
      else        ref_prev <= ref_level;
   end

   assign tick = use_core | (ref_level & ~ref_prev);

endmodule

// File: rtl/pdt_regif.sv
module pdt_regif
   import pdt_pkg::*;
#(
   parameter int          ADDR_W    = 4,
   parameter int          DATA_W    = 32,
   parameter int          CNT_W     = 24,
   parameter logic [31:0] CALIB_VAL = 32'h0000_0004
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wdata,
   input  logic              rd_en,
   input  logic [CNT_W-1:0]  count,
   input  logic              flag,
   output logic [DATA_W-1:0] rdata,
   output pdt_ctrl_t         ctrl,
   output logic [CNT_W-1:0]  reload,
   output logic              count_wr,
   output logic              ctrl_rd
);

   localparam int PAD_W = DATA_W - CNT_W;

   logic     hit;
   pdt_reg_e sel;

   assign sel = pdt_reg_e'(addr[3:2]);

   generate
      if (ADDR_W > 4) begin : g_wide
         assign hit = (addr[ADDR_W-1:4] == '0);
      end else begin : g_exact
         assign hit = 1'b1;
      end
   endgenerate

   logic ctrl_wr, reload_wr;
   assign ctrl_wr   = wr_en & hit & (sel == REG_CTRL);
   assign reload_wr = wr_en & hit & (sel == REG_RELOAD);
   assign count_wr  = wr_en & hit & (sel == REG_COUNT);
   assign ctrl_rd   = rd_en & hit & (sel == REG_CTRL);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl   <= '0;
         reload <= '0;
      end else begin
         if (ctrl_wr) begin
            ctrl.run      <= wdata[CTRL_EN_BIT];
            ctrl.irq_en   <= wdata[CTRL_IE_BIT];
            ctrl.core_src <= wdata[CTRL_SRC_BIT];
         end
         if (reload_wr) reload <= wdata[CNT_W-1:0];
      end
   end

   always_comb begin
      rdata = '0;
      if (rd_en && hit) begin
         unique case (sel)
            REG_CTRL: begin
               rdata[CTRL_EN_BIT]   = ctrl.run;
               rdata[CTRL_IE_BIT]   = ctrl.irq_en;
               rdata[CTRL_SRC_BIT]  = ctrl.core_src;
               rdata[CTRL_FLAG_BIT] = flag;
            end
            REG_RELOAD: rdata = {{PAD_W{1'b0}}, reload};
            REG_COUNT:  rdata = {{PAD_W{1'b0}}, count};
            REG_CALIB:  rdata = CALIB_VAL[DATA_W-1:0];
            default:    rdata = '0;
         endcase
      end
   end

   logic unused_addr_bits;
   assign unused_addr_bits = ^addr[1:0];

endmodule

// File: rtl/pdt_counter.sv
module pdt_counter #(
   parameter int CNT_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             active,
   input  logic [CNT_W-1:0] reload,
   input  logic             count_wr,
   input  logic             flag_clr,
   input  logic             irq_en,
   output logic [CNT_W-1:0] count,
   output logic             flag,
   output logic             irq
);

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic at_zero, last_step;
   assign at_zero   = (count == '0);
   assign last_step = active & (count == ONE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count <= '0;
         flag  <= 1'b0;
         irq   <= 1'b0;
      end else if (count_wr) begin
         count <= '0;
         flag  <= 1'b0;
         irq   <= 1'b0;
      end else begin
         irq <= last_step & irq_en;
         if (active) begin
            if (at_zero) count <= reload;
            else         count <= count - ONE;
         end
         if (flag_clr)  flag <= 1'b0;
         if (last_step) flag <= 1'b1;
      end
   end

endmodule

// File: rtl/periodic_down_timer.sv
module periodic_down_timer
   import pdt_pkg::*;
#(
   parameter int          ADDR_W      = 4,
   parameter int          DATA_W      = 32,
   parameter int          CNT_W       = 24,
   parameter int          SYNC_STAGES = 2,
   parameter logic [31:0] CALIB_VAL   = 32'h0000_0004
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_rd,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              dbg_halt,
   input  logic              ref_tick,
   output logic              irq
);

   generate
      if (ADDR_W < 4) begin : g_bad_addr
         $error("ADDR_W must be at least 4");
      end
      if (DATA_W <= CTRL_FLAG_BIT || DATA_W > 32) begin : g_bad_data
         $error("DATA_W must lie in 17..32");
      end
      if (CNT_W < 2 || CNT_W >= DATA_W) begin : g_bad_cnt
         $error("CNT_W must lie in 2..DATA_W-1");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must lie in 0..4");
      end
   endgenerate

   pdt_ctrl_t        ctrl;
   logic [CNT_W-1:0] reload;
   logic [CNT_W-1:0] count;
   logic             flag;
   logic             count_wr;
   logic             ctrl_rd;
   logic             tick;
   logic             active;

   pdt_regif #(
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .CNT_W     (CNT_W),
      .CALIB_VAL (CALIB_VAL)
   ) u_regif (
      .clk      (clk),
      .rst_n    (rst_n),
      .addr     (bus_addr),
      .wr_en    (bus_wr),
      .wdata    (bus_wdata),
      .rd_en    (bus_rd),
      .count    (count),
      .flag     (flag),
      .rdata    (bus_rdata),
      .ctrl     (ctrl),
      .reload   (reload),
      .count_wr (count_wr),
      .ctrl_rd  (ctrl_rd)
   );

   pdt_tick_gen #(
      .SYNC_STAGES (SYNC_STAGES)
   ) u_tick (
      .clk      (clk),
      .rst_n    (rst_n),
      .use_core (ctrl.core_src),
      .ref_in   (ref_tick),
      .tick     (tick)
   );

   assign active = ctrl.run & tick & ~dbg_halt;

   pdt_counter #(
      .CNT_W (CNT_W)
   ) u_counter (
      .clk      (clk),
      .rst_n    (rst_n),
      .active   (active),
      .reload   (reload),
      .count_wr (count_wr),
      .flag_clr (ctrl_rd),
      .irq_en   (ctrl.irq_en),
      .count    (count),
      .flag     (flag),
      .irq      (irq)
   );

endmodule

// File: rtl/pdt_checker.sv
module pdt_checker #(
   parameter int ADDR_W = 4,
   parameter int DATA_W = 32,
   parameter int CNT_W  = 24
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_rd,
   input logic [DATA_W-1:0] bus_rdata,
   input logic              dbg_halt,
   input logic              irq,
   input logic              active,
   input logic              count_wr,
   input logic              ctrl_rd,
   input logic              irq_en,
   input logic [CNT_W-1:0]  count,
   input logic [CNT_W-1:0]  reload,
   input logic              flag
);

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   assert_irq_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq);

   assert_irq_needs_enable_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (active && count == ONE && !count_wr && !irq_en) |=> !irq);

   assert_count_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
      count_wr |=> (count == '0 && !flag && !irq));

   assert_halt_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (dbg_halt && !count_wr) |=> $stable(count));

   assert_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (active && count == '0 && !count_wr) |=> count == $past(reload));

   assert_wrap_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (active && count == ONE && !count_wr) |=> flag);

   assert_read_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_rd && !(active && count == ONE)) |=> !flag);

   assert_upper_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr[3:2] != 2'd0 && bus_addr[3:2] != 2'd3)
         |-> bus_rdata[DATA_W-1:CNT_W] == '0);

endmodule

bind periodic_down_timer pdt_checker #(
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W),
   .CNT_W  (CNT_W)
) u_pdt_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_rd    (bus_rd),
   .bus_rdata (bus_rdata),
   .dbg_halt  (dbg_halt),
   .irq       (irq),
   .active    (active),
   .count_wr  (count_wr),
   .ctrl_rd   (ctrl_rd),
   .irq_en    (ctrl.irq_en),
   .count     (count),
   .reload    (reload),
   .flag      (flag)
);

// File: tb/periodic_down_timer_test.sv
module periodic_down_timer_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic        bus_rd = 1'b0;
   logic [31:0] bus_rdata;
   logic        dbg_halt = 1'b0;
   logic        ref_tick = 1'b0;
   logic        irq;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   periodic_down_timer uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_wr    (bus_wr),
      .bus_wdata (bus_wdata),
      .bus_rd    (bus_rd),
      .bus_rdata (bus_rdata),
      .dbg_halt  (dbg_halt),
      .ref_tick  (ref_tick),
      .irq       (irq)
   );

   // Bench model of the requirements, core-clock ticks only
   logic [23:0] m_cnt, m_rel;
   logic        m_flag, m_en, m_ie, m_src, m_irq;

   function automatic logic [31:0] exp_read(input logic [3:0] a);
      case (a[3:2])
         2'd0:    return {15'd0, m_flag, 13'd0, m_src, m_ie, m_en};
         2'd1:    return {8'd0, m_rel};
         2'd2:    return {8'd0, m_cnt};
         default: return 32'h0000_0004;
      endcase
   endfunction

   task automatic model_edge(input logic w, input logic r, input logic [3:0] a,
                             input logic [31:0] d, input logic h);
      logic act, set;
      act   = m_en && m_src && !h;
      set   = 1'b0;
      m_irq = 1'b0;
      if (w && a[3:2] == 2'd2) begin
         m_cnt  = '0;
         m_flag = 1'b0;
      end else begin
         if (act) begin
            if (m_cnt == 0) m_cnt = m_rel;
            else begin
               if (m_cnt == 1) begin set = 1'b1; m_irq = m_ie; end
               m_cnt = m_cnt - 1;
            end
         end
         if (r && a[3:2] == 2'd0) m_flag = 1'b0;
         if (set) m_flag = 1'b1;
      end
      if (w && a[3:2] == 2'd0) begin
         m_en = d[0]; m_ie = d[1]; m_src = d[2];
      end
      if (w && a[3:2] == 2'd1) m_rel = d[23:0];
   endtask

   task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   // One bus cycle; called at a negative edge, returns at the next one
   task automatic cyc(input logic w, input logic r, input logic [3:0] a,
                      input logic [31:0] d, input logic h, input string req);
      bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = d; dbg_halt = h;
      #1;
      if (r) check(bus_rdata, exp_read(a), req);
      @(posedge clk);
      model_edge(w, r, a, d, h);
      @(negedge clk);
      check({31'd0, irq}, {31'd0, m_irq}, "R9");
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) cyc(0, 0, 4'h0, 32'h0, 0, "R9");
   endtask

   // Raw access, no model (external tick phase)
   task automatic raw_read(input logic [3:0] a, input logic [31:0] exp, input string req);
      bus_wr = 0; bus_rd = 1; bus_addr = a; #1;
      check(bus_rdata, exp, req);
      @(negedge clk); bus_rd = 0;
   endtask

   task automatic raw_write(input logic [3:0] a, input logic [31:0] d);
      bus_wr = 1; bus_rd = 0; bus_addr = a; bus_wdata = d;
      @(negedge clk); bus_wr = 0;
   endtask

   initial begin
      #(10 * 150000);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      m_cnt = 0; m_rel = 0; m_flag = 0; m_en = 0; m_ie = 0; m_src = 0; m_irq = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: reset values
      check({31'd0, irq}, 32'd0, "R1");
      cyc(0, 1, 4'h0, 0, 0, "R1");
      cyc(0, 1, 4'h4, 0, 0, "R1");
      cyc(0, 1, 4'h8, 0, 0, "R1");
      cyc(0, 1, 4'hC, 0, 0, "R1");

      // R11: layout, flag not writable, calib fixed, upper bits zero
      cyc(1, 0, 4'hC, 32'h1234_5678, 0, "R11");
      cyc(0, 1, 4'hF, 0, 0, "R11");
      cyc(1, 0, 4'h4, 32'hFFFF_FFFF, 0, "R11");
      cyc(0, 1, 4'h5, 0, 0, "R11");
      cyc(1, 0, 4'h0, 32'hFFFF_FFF8, 0, "R11");
      cyc(0, 1, 4'h0, 0, 0, "R11");

      // R2/R3/R4/R12: count with reload 5 and irq enabled
      cyc(1, 0, 4'h4, 32'd5, 0, "R3");
      cyc(1, 0, 4'h8, 32'hDEAD, 0, "R6");
      cyc(1, 0, 4'h0, 32'h0000_0007, 0, "R2");
      for (int i = 0; i < 14; i++) cyc(0, 1, 4'h8, 0, 0, "R2");
      cyc(0, 1, 4'h0, 0, 0, "R4");
      cyc(0, 1, 4'h0, 0, 0, "R5");

      // R5: read in the very cycle of a 1->0 step keeps the flag
      while (m_cnt != 1) idle(1);
      cyc(0, 1, 4'h0, 0, 0, "R5");
      cyc(0, 1, 4'h0, 0, 0, "R5");
      cyc(0, 1, 4'h0, 0, 0, "R5");

      // R6: count write landing on a would-be wrap, no irq
      while (m_cnt != 1) idle(1);
      cyc(1, 0, 4'h8, 32'hFFFF_FFFF, 0, "R6");
      cyc(0, 1, 4'h8, 0, 0, "R6");
      cyc(0, 1, 4'h0, 0, 0, "R6");
      cyc(0, 1, 4'h8, 0, 0, "R6");

      // R7: zero reload parks the counter
      cyc(1, 0, 4'h4, 32'd0, 0, "R7");
      cyc(1, 0, 4'h8, 32'd0, 0, "R7");
      for (int i = 0; i < 8; i++) cyc(0, 1, 4'h8, 0, 0, "R7");
      cyc(0, 1, 4'h0, 0, 0, "R7");

      // R8: halt mid-count
      cyc(1, 0, 4'h4, 32'd10, 0, "R8");
      idle(4);
      for (int i = 0; i < 6; i++) cyc(0, 1, 4'h8, 0, 1, "R8");
      for (int i = 0; i < 4; i++) cyc(0, 1, 4'h8, 0, 0, "R8");

      // Random phase, core clock, short reload values
      begin
         int unsigned s;
         s = $urandom(32'h5EED_0042);
         for (int i = 0; i < 4000; i++) begin
            int unsigned op;
            op = $urandom_range(0, 99);
            if (op < 4)
               cyc(1, 0, 4'h0, $urandom | 32'h4, $urandom_range(0, 7) == 0, "R9");
            else if (op < 8)
               cyc(1, 0, 4'h4 | 4'($urandom_range(0, 3)), 32'($urandom_range(0, 6)), 0, "R3");
            else if (op < 10)
               cyc(1, 0, 4'h8, $urandom, 0, "R6");
            else if (op < 40)
               cyc(0, 1, 4'($urandom_range(0, 15)), 0, $urandom_range(0, 9) == 0, "R12");
            else
               cyc(0, 0, 4'h0, 0, $urandom_range(0, 9) == 0, "R2");
         end
      end

      // R10: external reference ticks
      cyc(1, 0, 4'h0, 32'h0000_0001, 0, "R10");
      cyc(1, 0, 4'h4, 32'd100, 0, "R10");
      cyc(1, 0, 4'h8, 32'd0, 0, "R10");
      repeat (10) @(negedge clk);
      raw_read(4'h8, 32'd0, "R10");
      for (int k = 0; k < 8; k++) begin
         ref_tick = 1'b1; repeat (4) @(negedge clk);
         ref_tick = 1'b0; repeat (4) @(negedge clk);
      end
      repeat (6) @(negedge clk);
      raw_read(4'h8, 32'd93, "R10");
      repeat (20) @(negedge clk);
      raw_read(4'h8, 32'd93, "R10");
      raw_write(4'h0, 32'h0000_0005);
      repeat (5) @(negedge clk);
      raw_read(4'h8, 32'd88, "R10");

      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule